// File: doc/BRIEF.md
# Multi-Mode Prescaled Timer Core

This block is a single timer: an optional down-counting prescaler produces ticks, and an up-counter advances by one on each tick. The counter can run in three modes. In free-run mode it wraps through the whole counter range. In periodic mode it returns to zero after the auto-reload value. In one-shot mode it climbs to the auto-reload value once, then stops and asks the surrounding logic to drop its enable bit. Several compare channels watch the counter, and each emits a pulse when the counter steps onto that channel's value.

Register decoding and interrupt collection sit outside the block. The counter preload is the only data that flows in, so it is a valid/ready stream. Ready is high exactly while the timer is stopped (`enable_i` low), and a word is taken on a clock edge where valid and ready are both high. While the timer runs, ready stays low and the producer must hold its word. All other pins are plain levels or one-cycle pulses. The pulse outputs are registered. Each one rises in the same cycle as the counter value it describes.

Top module: `prescaled_timer_core`

## Requirements
- R1: After reset `count_o` is 0, and `overflow_o`, `match_o` and `en_clear_o` are low. `preload_ready_o` is high while `enable_i` is low.
- R2: With a prescaler of width `PRE_W`>0 and reload value P, the prescaler reloads while the timer is stopped. Once the timer is enabled, the counter advances exactly once every P+1 enabled clocks, and the first advance comes on the (P+1)-th enabled clock.
- R3: With `PRE_W`=0 the prescaler is absent, `pre_reload_i` is ignored, and the counter advances on every enabled clock.
- R4: Mode code 0 (free-run) ignores `reload_i`. The counter steps from all-ones to 0, and `overflow_o` pulses in the cycle where `count_o` shows that 0.
- R5: Mode code 1 (periodic): on a tick where the counter equals `reload_i`, the counter returns to 0 and `overflow_o` pulses. Counting then continues.
- R6: Mode code 2 (one-shot): on the tick where the counter equals `reload_i`, the counter returns to 0, and `overflow_o` and `en_clear_o` pulse together for one cycle. After that the counter stays at 0 until `enable_i` has been low.
- R7: Mode code 3 behaves exactly like free-run.
- R8: Channel i (compare value at `cmp_vals_i[i*CNT_W +: CNT_W]`) pulses `match_o[i]` for one cycle, in the cycle where `count_o` first shows a value equal to its compare value after an advance. Channels fire independently and can fire in the same cycle.
- R9: A counter that does not advance produces no compare pulse. This holds for a counter that is stopped at a match value and for a counter that was preloaded to one.
- R10: A preload word is taken only when `enable_i` is low. The counter shows it in the next cycle. While the timer runs, a valid preload is refused and the counter is unchanged.
- R11: `overflow_o` and `match_o` come from registers. A wrap pulse always coincides with `count_o` = 0, and a stopped timer emits no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run/stop level |
| mode_i | input | 2 | 0 free-run, 1 periodic, 2 one-shot, 3 free-run |
| pre_reload_i | input | max(PRE_W,1) | Prescaler reload value (unused when PRE_W=0) |
| reload_i | input | CNT_W | Auto-reload value |
| cmp_vals_i | input | NUM_CH*CNT_W | Compare values, channel i at bits i*CNT_W upward |
| preload_valid_i | input | 1 | Preload word offered |
| preload_ready_o | output | 1 | Preload can be taken (timer stopped) |
| preload_data_i | input | CNT_W | Preload word |
| count_o | output | CNT_W | Live counter value |
| overflow_o | output | 1 | One-cycle wrap/reload event |
| match_o | output | NUM_CH | One-cycle compare pulses |
| en_clear_o | output | 1 | One-cycle request to clear the enable bit |

## Verification
The bench targets the wrap boundaries: all-ones to zero in free-run mode, and an auto-reload value equal to all-ones in periodic mode. A design that wraps one count early or late ends the run on a different counter value and counts a different number of overflow pulses. In one-shot mode the bench keeps enable high after completion. A core that has no completion latch would keep counting and report a nonzero counter. The bench also parks the counter on a compare value and offers a preload while the timer runs. These cases catch a level-sensitive comparator that repeats its pulse and a preload path that is not gated by enable. A run with a slow prescaler shows whether ticks are spaced P+1 clocks apart or P.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    PTC_FREE     = 2'd0,
    PTC_PERIODIC = 2'd1,
    PTC_ONESHOT  = 2'd2
  } ptc_mode_e;

  // Code 3 folds onto free-run.
  function automatic ptc_mode_e ptc_decode(input logic [1:0] code);
    ptc_mode_e m;
    case (code)
      2'd1:    m = PTC_PERIODIC;
      2'd2:    m = PTC_ONESHOT;
      default: m = PTC_FREE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
  parameter int PRE_W  = 8,
  parameter int PRE_PW = (PRE_W > 0) ? PRE_W : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [PRE_PW-1:0] reload_i,
  output logic              tick_o
);

  generate
    if (PRE_W == 0) begin : g_bypass
      // No divider: every running clock is a tick.
      logic unused_bypass;
      assign unused_bypass = ^{reload_i, clk, rst_n};
      assign tick_o        = run_i;
    end else begin : g_div
      logic [PRE_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q <= '0;
        end else if (!run_i) begin
          div_q <= reload_i;
        end else if (div_q == '0) begin
          div_q <= reload_i;
        end else begin
          div_q <= div_q - 1'b1;
        end
      end

      assign tick_o = run_i && (div_q == '0);
    end
  endgenerate

endmodule

// File: rtl/ptc_counter.sv
module ptc_counter
  import ptc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             pl_take_i,
  input  logic [CNT_W-1:0] pl_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             adv_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic             clr_o
);

  ptc_mode_e        mode;
  logic [CNT_W-1:0] count_q;
  logic             done_q;
  logic             ovf_q;
  logic             clr_q;
  logic             at_top;
  logic             all_ones;
  logic             wrap;
  logic             finish;

  assign mode     = ptc_decode(mode_i);
  assign at_top   = (count_q == reload_i);
  assign all_ones = &count_q;
  assign adv_o    = tick_i;

  always_comb begin
    wrap  = 1'b0;
    nxt_o = count_q + 1'b1;
    case (mode)
      PTC_PERIODIC, PTC_ONESHOT: begin
        if (at_top) begin
          wrap  = 1'b1;
          nxt_o = '0;
        end
      end
      default: wrap = all_ones;
    endcase
  end

  assign finish = tick_i && (mode == PTC_ONESHOT) && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (tick_i) begin
      count_q <= nxt_o;
    end else if (pl_take_i) begin
      count_q <= pl_data_i;
    end
  end

  // Completion latch: holds the counter until enable has dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (!enable_i) begin
      done_q <= 1'b0;
    end else if (finish) begin
      done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      ovf_q <= tick_i && wrap;
      clr_q <= finish;
    end
  end

  assign count_o = count_q;
  assign done_o  = done_q;
  assign ovf_o   = ovf_q;
  assign clr_o   = clr_q;

endmodule

// File: rtl/ptc_compare.sv
module ptc_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             hit_o
);

  logic hit_q;

  // Compares the value being stepped onto, so a parked counter stays quiet.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= adv_i && (nxt_i == cmp_i);
    end
  end

  assign hit_o = hit_q;

endmodule

// File: rtl/prescaled_timer_core.sv
module prescaled_timer_core #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4,
  parameter int PRE_W  = 8,
  localparam int PRE_PW = (PRE_W > 0) ? PRE_W : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable_i,
  input  logic [1:0]              mode_i,
  input  logic [PRE_PW-1:0]       pre_reload_i,
  input  logic [CNT_W-1:0]        reload_i,
  input  logic [NUM_CH*CNT_W-1:0] cmp_vals_i,
  input  logic                    preload_valid_i,
  output logic                    preload_ready_o,
  input  logic [CNT_W-1:0]        preload_data_i,
  output logic [CNT_W-1:0]        count_o,
  output logic                    overflow_o,
  output logic [NUM_CH-1:0]       match_o,
  output logic                    en_clear_o
);

  logic             run;
  logic             tick;
  logic             done;
  logic             adv;
  logic             pl_take;
  logic [CNT_W-1:0] nxt;

  assign preload_ready_o = !enable_i;
  assign pl_take         = preload_valid_i && preload_ready_o;
  assign run             = enable_i && !done;

  ptc_prescaler #(
    .PRE_W (PRE_W),
    .PRE_PW(PRE_PW)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .reload_i(pre_reload_i),
    .tick_o  (tick)
  );

  ptc_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .tick_i   (tick),
    .mode_i   (mode_i),
    .reload_i (reload_i),
    .pl_take_i(pl_take),
    .pl_data_i(preload_data_i),
    .count_o  (count_o),
    .nxt_o    (nxt),
    .adv_o    (adv),
    .done_o   (done),
    .ovf_o    (overflow_o),
    .clr_o    (en_clear_o)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      ptc_compare #(
        .CNT_W(CNT_W)
      ) u_cmp (
        .clk  (clk),
        .rst_n(rst_n),
        .adv_i(adv),
        .nxt_i(nxt),
        .cmp_i(cmp_vals_i[ch*CNT_W +: CNT_W]),
        .hit_o(match_o[ch])
      );
    end
  endgenerate

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable_i,
  input logic [1:0]              mode_i,
  input logic [NUM_CH*CNT_W-1:0] cmp_vals_i,
  input logic                    preload_valid_i,
  input logic [CNT_W-1:0]        preload_data_i,
  input logic [CNT_W-1:0]        count_o,
  input logic                    overflow_o,
  input logic [NUM_CH-1:0]       match_o,
  input logic                    en_clear_o
);

  // R4 R5 R11
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (count_o == '0));

  // R6
  clr_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clear_o |-> (overflow_o && ($past(mode_i) == 2'd2)));

  // R10
  preload_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && preload_valid_i) |=> (count_o == $past(preload_data_i)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !preload_valid_i) |=> $stable(count_o));

  // R9 R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!overflow_o && (match_o == '0) && !en_clear_o));

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
      // R8
      match_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o[ch] |-> (count_o == $past(cmp_vals_i[ch*CNT_W +: CNT_W])));
    end
  endgenerate

endmodule

bind prescaled_timer_core ptc_checker #(
  .CNT_W (CNT_W),
  .NUM_CH(NUM_CH)
) u_ptc_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .enable_i       (enable_i),
  .mode_i         (mode_i),
  .cmp_vals_i     (cmp_vals_i),
  .preload_valid_i(preload_valid_i),
  .preload_data_i (preload_data_i),
  .count_o        (count_o),
  .overflow_o     (overflow_o),
  .match_o        (match_o),
  .en_clear_o     (en_clear_o)
);

// File: tb/prescaled_timer_core_tb_top.sv
module prescaled_timer_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int NC = 2;
  localparam int PW = 3;

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] rel;
    logic [2:0] pre;
    logic [3:0] pl;
    logic [3:0] cmp;
    logic [7:0] n;
    logic [3:0] e_cnt;
    logic [3:0] e_ovf;
    logic [3:0] e_m0;
    logic [3:0] e_clr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd3,  3'd0, 4'd0,  4'd5,  8'd20, 4'd4, 4'd1, 4'd1, 4'd0}, // R4 free-run, reload ignored
    '{2'd1, 4'd6,  3'd0, 4'd0,  4'd5,  8'd20, 4'd6, 4'd2, 4'd3, 4'd0}, // R5 periodic
    '{2'd1, 4'd6,  3'd2, 4'd0,  4'd5,  8'd20, 4'd6, 4'd0, 4'd1, 4'd0}, // R2 prescaled
    '{2'd2, 4'd4,  3'd0, 4'd0,  4'd3,  8'd10, 4'd0, 4'd1, 4'd1, 4'd1}, // R6 one-shot
    '{2'd3, 4'd2,  3'd1, 4'd0,  4'd5,  8'd36, 4'd2, 4'd1, 4'd1, 4'd0}, // R7 code 3
    '{2'd0, 4'd9,  3'd0, 4'd14, 4'd0,  8'd3,  4'd1, 4'd1, 4'd1, 4'd0}, // R4 wrap after preload
    '{2'd1, 4'd15, 3'd0, 4'd0,  4'd15, 8'd17, 4'd1, 4'd1, 4'd1, 4'd0}  // R5 reload at all-ones
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [PW-1:0] pre = '0;
  logic [CW-1:0] rel = '0;
  logic [CW-1:0] cmp0 = '0;
  logic [CW-1:0] cmp1 = 4'd15;
  logic          pl_valid = 1'b0;
  logic [CW-1:0] pl_data = '0;
  logic          pl_ready;
  logic [CW-1:0] count;
  logic          ovf;
  logic [NC-1:0] match;
  logic          clr;

  logic          enable_b = 1'b0;
  logic [CW-1:0] count_b;
  logic          ovf_b;
  logic [NC-1:0] match_b;
  logic          clr_b;
  logic          ready_b;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int n_ovf, n_m0, n_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_timer_core #(.CNT_W(CW), .NUM_CH(NC), .PRE_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .mode_i(mode),
    .pre_reload_i(pre), .reload_i(rel), .cmp_vals_i({cmp1, cmp0}),
    .preload_valid_i(pl_valid), .preload_ready_o(pl_ready),
    .preload_data_i(pl_data), .count_o(count), .overflow_o(ovf),
    .match_o(match), .en_clear_o(clr)
  );

  prescaled_timer_core #(.CNT_W(CW), .NUM_CH(NC), .PRE_W(0)) dut_nopre_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_b), .mode_i(2'd0),
    .pre_reload_i(1'b1), .reload_i(4'd2), .cmp_vals_i({4'd9, 4'd9}),
    .preload_valid_i(1'b0), .preload_ready_o(ready_b),
    .preload_data_i(4'd0), .count_o(count_b), .overflow_o(ovf_b),
    .match_o(match_b), .en_clear_o(clr_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic load(input logic [CW-1:0] v);
    enable   = 1'b0;
    pl_valid = 1'b1;
    pl_data  = v;
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(count == 0 && !ovf && match == 0 && !clr, "R1 reset outputs", count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 0 && pl_ready, "R1 idle after reset", {pl_ready, count}, 16);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      mode = VECS[i].mode;
      rel  = VECS[i].rel;
      pre  = VECS[i].pre;
      cmp0 = VECS[i].cmp;
      load(VECS[i].pl);
      chk(count == VECS[i].pl, "R10 preload", count, VECS[i].pl);
      n_ovf = 0; n_m0 = 0; n_clr = 0;
      enable = 1'b1;
      for (int k = 0; k < VECS[i].n; k++) begin
        @(negedge clk);
        n_ovf += ovf;
        n_m0  += match[0];
        n_clr += clr;
      end
      enable = 1'b0;
      chk(count == VECS[i].e_cnt, $sformatf("R2 R4 R5 R6 R7 vec%0d count", i), count, VECS[i].e_cnt);
      chk(n_ovf == VECS[i].e_ovf, $sformatf("R4 R5 vec%0d overflow pulses", i), n_ovf, VECS[i].e_ovf);
      chk(n_m0 == VECS[i].e_m0, $sformatf("R8 vec%0d match pulses", i), n_m0, VECS[i].e_m0);
      chk(n_clr == VECS[i].e_clr, $sformatf("R6 vec%0d clear pulses", i), n_clr, VECS[i].e_clr);
    end

    // R9 parked on a compare value
    cmp0 = 4'd5;
    load(4'd5);
    chk(match == 0, "R9 no match on preload", match, 0);
    repeat (3) begin
      @(negedge clk);
      chk(match == 0 && count == 5, "R9 stopped at match value", match, 0);
    end

    // R10 preload refused while running
    mode = 2'd0; pre = 3'd7;
    load(4'd0);
    enable = 1'b1; pl_valid = 1'b1; pl_data = 4'd9;
    #1;
    chk(!pl_ready, "R10 ready low while running", pl_ready, 0);
    repeat (3) @(negedge clk);
    chk(count == 0, "R10 preload ignored while running", count, 0);
    pl_valid = 1'b0; enable = 1'b0;
    @(negedge clk);

    // R8 two channels together
    pre = 3'd0; cmp0 = 4'd3; cmp1 = 4'd3;
    load(4'd2);
    enable = 1'b1;
    @(negedge clk);
    chk(count == 3 && match == 2'b11, "R8 both channels fire", match, 3);
    @(negedge clk);
    chk(count == 4 && match == 2'b00, "R8 pulse lasts one cycle", match, 0);
    enable = 1'b0;
    cmp1 = 4'd15;

    // R11 overflow aligned with zero, periodic reload 2
    mode = 2'd1; rel = 4'd2;
    load(4'd0);
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(count == 2 && !ovf, "R11 no pulse before wrap", ovf, 0);
    @(negedge clk);
    chk(count == 0 && ovf, "R11 overflow with count 0", {ovf, count}, 16);
    enable = 1'b0;

    // R6 one-shot holds after completion while enable stays high
    mode = 2'd2; rel = 4'd1;
    load(4'd0);
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(count == 0 && ovf && clr, "R6 completion pulses", {clr, ovf, count}, 48);
    @(negedge clk);
    @(negedge clk);
    chk(count == 0 && !ovf && !clr, "R6 holds until enable drops", {clr, ovf, count}, 0);
    enable = 1'b0;
    @(negedge clk);

    // R3 no prescaler: advance every clock
    enable_b = 1'b1;
    repeat (5) @(negedge clk);
    enable_b = 1'b0;
    chk(count_b == 5, "R3 no-prescaler advance rate", count_b, 5);

    finish_run();
  end

endmodule